// File: doc/BRIEF.md
# Add/Multiply Accumulating Register Datapath

This block is a small register-transfer datapath built around two registers: a source register that captures the external data bus when its load strobe is raised, and an accumulator whose content is the block's only output. Each clock, four coded control inputs choose the operands of an adder and a multiplier, pick which of four candidate values may reach the accumulator, and decide whether the accumulator is cleared, kept or loaded.

The adder and the multiplier each take the accumulator as one operand and a selectable second operand, either the source register or the data bus. The result selector chooses among the sum, the data bus, the source register and the product. All arithmetic is truncated to the data width, and every register changes only on the rising clock edge. Sequencing of the control inputs belongs to the surrounding logic.

Top module: `addmul_datapath`

## Requirements
- R1: When `rst` is high at a rising edge, both the source register and the accumulator become zero, so `acc_out` reads 0 after that edge.
- R2: With `acc_op` = 0 the accumulator becomes zero at the next edge.
- R3: With `acc_op` = 1, and also with `acc_op` = 3, the accumulator keeps its value whatever the other control and data inputs are.
- R4: With `acc_op` = 2 and `res_sel` = 1 the accumulator loads `din`.
- R5: With `acc_op` = 2 and `res_sel` = 2 the accumulator loads the source register value held before the edge.
- R6: With `acc_op` = 2 and `res_sel` = 0 the accumulator loads (A + accumulator) mod 2^W, where A is the source register when `add_sel` = 0 and `din` when `add_sel` = 1.
- R7: With `acc_op` = 2 and `res_sel` = 3 the accumulator loads (B * accumulator) mod 2^W, where B is the source register when `mul_sel` = 0 and `din` when `mul_sel` = 1.
- R8: The source register captures `din` only at edges where `src_load` is high; otherwise it keeps its value.
- R9: When `src_load` is high and the accumulator loads the source register at the same edge, the accumulator receives the old source value and the new one is seen only from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of both registers |
| din | input | W | External data bus |
| src_load | input | 1 | Load strobe of the source register |
| add_sel | input | 1 | Adder operand: 0 source register, 1 data bus |
| mul_sel | input | 1 | Multiplier operand: 0 source register, 1 data bus |
| res_sel | input | 2 | Result choice: 0 sum, 1 data bus, 2 source register, 3 product |
| acc_op | input | 2 | Accumulator action: 0 clear, 1 hold, 2 load, 3 hold |
| acc_out | output | W | Accumulator content |

## Verification
The bench builds the datapath with a 4-bit data width, which makes every pair of source and accumulator values reachable, so all 256 combinations are pushed through the sum and product paths and the carry and high product bits lost to truncation are exercised for every operand pair. The same sweep drives both operand selector settings, the bus and register bypass choices, and both hold codes with a changing bus, while separate sequences cover the same-edge load ordering and a reset in the middle of a run.

// File: rtl/addmul_pkg.sv
package addmul_pkg;

  typedef enum logic [1:0] {
    RES_SUM  = 2'd0,
    RES_BUS  = 2'd1,
    RES_SRC  = 2'd2,
    RES_PROD = 2'd3
  } res_sel_e;

  typedef enum logic [1:0] {
    ACC_CLEAR = 2'd0,
    ACC_KEEP  = 2'd1,
    ACC_LOAD  = 2'd2,
    ACC_KEEP2 = 2'd3
  } acc_op_e;

endpackage

// File: rtl/amd_opnd_mux.sv
module amd_opnd_mux #(
  parameter int W = 8
) (
  input  logic         pick_bus,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] bus_val,
  output logic [W-1:0] y
);
  always_comb y = pick_bus ? bus_val : reg_val;
endmodule

// File: rtl/amd_result_unit.sv
module amd_result_unit
  import addmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] add_opnd,
  input  logic [W-1:0] mul_opnd,
  input  logic [W-1:0] acc_val,
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] bus_val,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;

  logic [W-1:0]  sum;
  logic [PW-1:0] prod_full;

  always_comb begin
    sum       = add_opnd + acc_val;
    prod_full = PW'(mul_opnd) * PW'(acc_val);
  end

  always_comb begin
    case (res_sel_e'(sel))
      RES_SUM:  y = sum;
      RES_BUS:  y = bus_val;
      RES_SRC:  y = src_val;
      RES_PROD: y = prod_full[W-1:0];
      default:  y = sum;
    endcase
  end
endmodule

// File: rtl/amd_acc_reg.sv
module amd_acc_reg
  import addmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (acc_op_e'(op))
        ACC_CLEAR: q <= '0;
        ACC_LOAD:  q <= d;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/amd_src_reg.sv
module amd_src_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/addmul_datapath.sv
module addmul_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         src_load,
  input  logic         add_sel,
  input  logic         mul_sel,
  input  logic [1:0]   res_sel,
  input  logic [1:0]   acc_op,
  output logic [W-1:0] acc_out
);
  localparam int NOPND = 2;

  logic [W-1:0] src_q;
  logic [W-1:0] acc_q;
  logic [W-1:0] result;
  logic [NOPND-1:0]        opnd_pick;
  logic [NOPND-1:0][W-1:0] opnd;

  assign opnd_pick = {mul_sel, add_sel};

  amd_src_reg #(.W(W)) u_src (
    .clk(clk), .rst(rst), .load(src_load), .d(din), .q(src_q)
  );

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    amd_opnd_mux #(.W(W)) u_mux (
      .pick_bus(opnd_pick[i]),
      .reg_val (src_q),
      .bus_val (din),
      .y       (opnd[i])
    );
  end

  amd_result_unit #(.W(W)) u_res (
    .add_opnd(opnd[0]),
    .mul_opnd(opnd[1]),
    .acc_val (acc_q),
    .src_val (src_q),
    .bus_val (din),
    .sel     (res_sel),
    .y       (result)
  );

  amd_acc_reg #(.W(W)) u_acc (
    .clk(clk), .rst(rst), .op(acc_op), .d(result), .q(acc_q)
  );

  assign acc_out = acc_q;
endmodule

// File: rtl/addmul_datapath_sva.sv
module addmul_datapath_sva #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] din,
  input logic         src_load,
  input logic         add_sel,
  input logic         mul_sel,
  input logic [1:0]   res_sel,
  input logic [1:0]   acc_op,
  input logic [W-1:0] acc_out
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> acc_out == '0);

  // R2
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    acc_op == 2'd0 |=> acc_out == '0);

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    acc_op[0] |=> $stable(acc_out));

  // R4
  a_r4_bus_load: assert property (@(posedge clk) disable iff (rst)
    (acc_op == 2'd2 && res_sel == 2'd1) |=> acc_out == $past(din));

  // R6
  a_r6_bus_sum: assert property (@(posedge clk) disable iff (rst)
    (acc_op == 2'd2 && res_sel == 2'd0 && add_sel)
      |=> acc_out == W'($past(din) + $past(acc_out)));

  // R7
  a_r7_bus_prod: assert property (@(posedge clk) disable iff (rst)
    (acc_op == 2'd2 && res_sel == 2'd3 && mul_sel)
      |=> acc_out == W'($past(din) * $past(acc_out)));

  // R5 and R8: source path copied after a load with no intervening strobe
  a_r8_src_after_load: assert property (@(posedge clk) disable iff (rst)
    (src_load ##1 (!src_load && acc_op == 2'd2 && res_sel == 2'd2))
      |=> acc_out == $past(din, 2));
endmodule

bind addmul_datapath addmul_datapath_sva #(.W(W)) u_sva (.*);

// File: tb/addmul_datapath_bench.sv
module addmul_datapath_bench;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic         src_load = 1'b0;
  logic         add_sel = 1'b0;
  logic         mul_sel = 1'b0;
  logic [1:0]   res_sel = 2'd0;
  logic [1:0]   acc_op = 2'd1;
  logic [W-1:0] acc_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addmul_datapath #(.W(W)) u_addmul_datapath (
    .clk(clk), .rst(rst), .din(din), .src_load(src_load),
    .add_sel(add_sel), .mul_sel(mul_sel), .res_sel(res_sel),
    .acc_op(acc_op), .acc_out(acc_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (acc_out !== exp) begin
      fails++;
      $display("FAIL %s: acc_out=%0d expected %0d", req, acc_out, exp);
    end
  endtask

  task automatic set_src(logic [W-1:0] v);
    din = v; src_load = 1'b1; acc_op = 2'd1; step(); src_load = 1'b0;
  endtask

  task automatic set_acc(logic [W-1:0] v);
    din = v; acc_op = 2'd2; res_sel = 2'd1; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: acc_out=%0d expected completion", acc_out);
    finish_run();
  end

  initial begin
    step(); step();
    check("R1 reset", '0);
    rst = 1'b0;
    // R5: source must read zero after reset
    acc_op = 2'd2; res_sel = 2'd2; step();
    check("R1 source reset", '0);

    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        logic [W-1:0] av, bv, cv;
        av = W'(a); bv = W'(b); cv = ~av;
        set_src(av);
        set_acc(bv);
        check("R4 bus load", bv);
        add_sel = 1'b0; res_sel = 2'd0; din = cv; step();
        check("R6 src sum", W'(av + bv));
        set_acc(bv);
        mul_sel = 1'b0; res_sel = 2'd3; din = cv; step();
        check("R7 src prod", W'(av * bv));
        set_acc(bv);
        add_sel = 1'b1; res_sel = 2'd0; din = cv; step();
        check("R6 bus sum", W'(cv + bv));
        set_acc(bv);
        mul_sel = 1'b1; res_sel = 2'd3; din = cv; step();
        check("R7 bus prod", W'(cv * bv));
        // R8: bus changed many times without strobe, source must still hold av
        res_sel = 2'd2; din = bv; step();
        check("R5 R8 source copy", av);
        acc_op = 2'd1; res_sel = 2'd1; din = cv; step();
        check("R3 hold code 1", av);
        acc_op = 2'd3; res_sel = 2'd0; din = bv; step();
        check("R3 hold code 3", av);
        acc_op = 2'd0; step();
        check("R2 clear", '0);
      end
    end

    // R9: same-edge source load and source copy
    set_src(W'(3));
    din = W'(9); src_load = 1'b1; acc_op = 2'd2; res_sel = 2'd2; step();
    check("R9 old source", W'(3));
    src_load = 1'b0; din = W'(1); step();
    check("R9 new source", W'(9));

    // R1: reset mid-run clears both registers
    set_acc(W'(11));
    rst = 1'b1; acc_op = 2'd1; step();
    check("R1 mid-run reset", '0);
    rst = 1'b0; acc_op = 2'd2; res_sel = 2'd2; din = W'(7); step();
    check("R1 source cleared", '0);

    finish_run();
  end
endmodule